// File: doc/BRIEF.md
# RC Servo Command Pulse Generator

This block drives two hobby-servo style pulse outputs, one for the steering servo and one for the drive speed controller. Both outputs repeat a single high pulse once per 20 ms frame. The width of that pulse carries the command: 1.5 ms is centre or neutral, and 1.0 ms and 2.0 ms are the two extremes. A host processor writes small encoded commands into four command registers. There is one steering and one drive register for the user, and one steering and one drive register for the automatic safety controller. The block converts the selected codes into pulse widths.

An operating-mode input and a threat flag decide which register pair drives the outputs. In the manual modes the user always has the car. In the immediate-takeover mode a threat hands the car to the safety commands at the next frame. In the warning mode a warning output is raised first. If the threat is still present after a set number of frame boundaries, the safety commands take over. Widths and the frame are counted in ticks of a 1 us timebase, which a parameterised prescaler derives from the system clock. A new selection or a new command is only applied at a frame boundary, so a pulse is never cut short or stretched.

Top module: `servo_pulse_gen`

## Requirements
- R1: Each output frame lasts FRAME_TICKS ticks (20000, i.e. 20 ms). Each pulse output rises only at the start of a frame and stays high for exactly the selected width in ticks, then stays low for the rest of the frame.
- R2: One tick lasts TICK_DIV clock cycles. The frame position advances by one every TICK_DIV cycles.
- R3: Steering codes (3 bits) are: 0 = straight 1.5 ms, 1 = full left 1.0 ms, 2 = slight left 1.4 ms, 3 = slight right 1.6 ms, 4 = full right 2.0 ms. Codes 5, 6 and 7 give straight.
- R4: Drive codes (2 bits) are: 0 = neutral 1.5 ms, 1 = full forward 1.0 ms, 2 = full reverse 2.0 ms, 3 = neutral.
- R5: A write with wr_en high stores wr_data into the register picked by wr_addr: 0 = user steering, 1 = user drive, 2 = safety steering, 3 = safety drive. Steering registers take wr_data[2:0]. Drive registers take wr_data[1:0] and ignore wr_data[2].
- R6: A changed command or changed source selection takes effect only at the next frame boundary. A pulse already in progress keeps its width.
- R7: After reset all command registers hold 0. Both outputs start a frame with the 1.5 ms width, and warn_o is low.
- R8: With mode 0 or 1, the user registers drive both outputs whatever the threat input does.
- R9: With mode 3 and threat high at a frame boundary, the safety registers drive the next frame. When threat is low at a boundary, the user registers are used again.
- R10: With mode 2 and threat high, warn_o is high until the safety registers have taken over. Takeover happens at the first frame boundary at which the threat has already been present across WARN_FRAMES earlier boundaries.
- R11: Dropping threat or leaving mode 2, even for one clock, clears the count of warned frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Command register write strobe |
| wr_addr | input | 2 | Command register select |
| wr_data | input | 3 | Command code to write |
| mode | input | 2 | Operating mode: 0/1 manual, 2 warn then take over, 3 immediate takeover |
| threat | input | 1 | Collision threat flag from the decision logic |
| steer_pwm | output | 1 | Steering servo pulse train |
| drive_pwm | output | 1 | Drive controller pulse train |
| warn_o | output | 1 | Audible warning request while a takeover is pending |

## Verification
The pulse outputs are registered. Each one reflects the frame position and active width one clock after the edge that moved them. A register write or a mode or threat change therefore appears on the pulses only after the edge that closes the current frame. The bench's behavioural model counts functional edges from the end of the two-cycle reset release, applies writes after the boundary decision of the same edge, and compares every output half a cycle after each edge. warn_o depends combinationally on the present mode and threat and on the registered takeover state, so it is checked in the same cycle as the input change.

// File: rtl/servo_pkg.sv
package servo_pkg;

  localparam int STEER_CW = 3;
  localparam int DRIVE_CW = 2;

  typedef enum logic [1:0] {
    SEL_USER_STEER = 2'd0,
    SEL_USER_DRIVE = 2'd1,
    SEL_SAFE_STEER = 2'd2,
    SEL_SAFE_DRIVE = 2'd3
  } cmd_sel_e;

  localparam logic [1:0] MODE_WARN = 2'd2;
  localparam logic [1:0] MODE_AUTO = 2'd3;

  typedef struct packed {
    logic [STEER_CW-1:0] steer;
    logic [DRIVE_CW-1:0] drive;
  } cmd_pair_t;

endpackage

// File: rtl/servo_timebase.sv
module servo_timebase #(
  parameter int TICK_DIV    = 50,
  parameter int FRAME_TICKS = 20000,
  localparam int FW = $clog2(FRAME_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [FW-1:0] fr_cnt_q,
  output logic [FW-1:0] fr_cnt_d,
  output logic          frame_end
);

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        tick  = (pre_q == PW'(TICK_DIV - 1));
        pre_d = tick ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nodiv
      always_comb tick = 1'b1;
    end
  endgenerate

  always_comb begin
    frame_end = tick && (fr_cnt_q == FW'(FRAME_TICKS - 1));
    fr_cnt_d  = fr_cnt_q;
    if (tick) fr_cnt_d = frame_end ? '0 : fr_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fr_cnt_q <= '0;
    else        fr_cnt_q <= fr_cnt_d;
  end

endmodule

// File: rtl/servo_cmd_regs.sv
module servo_cmd_regs
  import servo_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  cmd_sel_e            wr_sel,
  input  logic [STEER_CW-1:0] wr_data,
  output cmd_pair_t           user_cmd,
  output cmd_pair_t           safe_cmd
);

  cmd_pair_t user_d, safe_d;

  always_comb begin
    user_d = user_cmd;
    safe_d = safe_cmd;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_USER_STEER: user_d.steer = wr_data;
        SEL_USER_DRIVE: user_d.drive = wr_data[DRIVE_CW-1:0];
        SEL_SAFE_STEER: safe_d.steer = wr_data;
        SEL_SAFE_DRIVE: safe_d.drive = wr_data[DRIVE_CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_cmd <= '0;
      safe_cmd <= '0;
    end else begin
      user_cmd <= user_d;
      safe_cmd <= safe_d;
    end
  end

endmodule

// File: rtl/servo_override.sv
module servo_override
  import servo_pkg::*;
#(
  parameter int WARN_FRAMES = 25,
  localparam int CW = $clog2(WARN_FRAMES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       threat,
  input  logic       frame_end,
  output logic       take_now,
  output logic       warn_o
);

  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          src_safe_q, src_safe_d;
  logic          pending, warned_out;

  always_comb begin
    pending    = (mode == MODE_WARN) && threat;
    warned_out = (wcnt_q >= CW'(WARN_FRAMES));
    take_now   = ((mode == MODE_AUTO) && threat) || (pending && warned_out);
    if (!pending)                     wcnt_d = '0;
    else if (frame_end && !warned_out) wcnt_d = wcnt_q + 1'b1;
    else                              wcnt_d = wcnt_q;
    src_safe_d = frame_end ? take_now : src_safe_q;
    warn_o     = pending && !src_safe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q     <= '0;
      src_safe_q <= 1'b0;
    end else begin
      wcnt_q     <= wcnt_d;
      src_safe_q <= src_safe_d;
    end
  end

endmodule

// File: rtl/servo_channel.sv
module servo_channel #(
  parameter bit IS_STEER = 1'b1,
  parameter int FW       = 15,
  parameter int W_MIN    = 1000,
  parameter int W_SLO    = 1400,
  parameter int W_MID    = 1500,
  parameter int W_SHI    = 1600,
  parameter int W_MAX    = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd,
  input  logic          load,
  input  logic [FW-1:0] fr_cnt_d,
  output logic          pwm
);

  logic [FW-1:0] width_q, width_d, width_dec;
  logic          pwm_d;

  generate
    if (IS_STEER) begin : g_steer
      always_comb begin
        unique case (cmd)
          3'd1:    width_dec = FW'(W_MIN);
          3'd2:    width_dec = FW'(W_SLO);
          3'd3:    width_dec = FW'(W_SHI);
          3'd4:    width_dec = FW'(W_MAX);
          default: width_dec = FW'(W_MID);
        endcase
      end
    end else begin : g_drive
      always_comb begin
        unique case (cmd)
          3'd1:    width_dec = FW'(W_MIN);
          3'd2:    width_dec = FW'(W_MAX);
          default: width_dec = FW'(W_MID);
        endcase
      end
    end
  endgenerate

  always_comb begin
    width_d = load ? width_dec : width_q;
    pwm_d   = (fr_cnt_d < width_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= FW'(W_MID);
      pwm     <= 1'b1;
    end else begin
      width_q <= width_d;
      pwm     <= pwm_d;
    end
  end

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int FRAME_TICKS = 20000,
  parameter int W_MIN       = 1000,
  parameter int W_SLO       = 1400,
  parameter int W_MID       = 1500,
  parameter int W_SHI       = 1600,
  parameter int W_MAX       = 2000,
  parameter int WARN_FRAMES = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [2:0] wr_data,
  input  logic [1:0] mode,
  input  logic       threat,
  output logic       steer_pwm,
  output logic       drive_pwm,
  output logic       warn_o
);

  localparam int FW    = $clog2(FRAME_TICKS);
  localparam int N_CH  = 2;

  logic          rst_s1, rst_i;
  logic [FW-1:0] fr_cnt_q, fr_cnt_d;
  logic          frame_end, take_now;
  cmd_pair_t     user_cmd, safe_cmd, sel_cmd;
  logic [2:0]    ch_cmd [N_CH];
  logic [N_CH-1:0] pwm_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  servo_timebase #(.TICK_DIV(TICK_DIV), .FRAME_TICKS(FRAME_TICKS)) u_tb (
    .clk(clk), .rst_n(rst_i), .fr_cnt_q(fr_cnt_q), .fr_cnt_d(fr_cnt_d),
    .frame_end(frame_end)
  );

  servo_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_sel(cmd_sel_e'(wr_addr)),
    .wr_data(wr_data), .user_cmd(user_cmd), .safe_cmd(safe_cmd)
  );

  servo_override #(.WARN_FRAMES(WARN_FRAMES)) u_ovr (
    .clk(clk), .rst_n(rst_i), .mode(mode), .threat(threat),
    .frame_end(frame_end), .take_now(take_now), .warn_o(warn_o)
  );

  always_comb begin
    sel_cmd   = take_now ? safe_cmd : user_cmd;
    ch_cmd[0] = sel_cmd.steer;
    ch_cmd[1] = {1'b0, sel_cmd.drive};
  end

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      servo_channel #(
        .IS_STEER(g == 0), .FW(FW), .W_MIN(W_MIN), .W_SLO(W_SLO),
        .W_MID(W_MID), .W_SHI(W_SHI), .W_MAX(W_MAX)
      ) u_ch (
        .clk(clk), .rst_n(rst_i), .cmd(ch_cmd[g]), .load(frame_end),
        .fr_cnt_d(fr_cnt_d), .pwm(pwm_vec[g])
      );
    end
  endgenerate

  assign steer_pwm = pwm_vec[0];
  assign drive_pwm = pwm_vec[1];

endmodule

// File: rtl/servo_pulse_chk.sv
module servo_pulse_chk #(
  parameter int TICK_DIV = 50,
  parameter int FW       = 15,
  parameter int W_MIN    = 1000,
  parameter int W_MAX    = 2000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [FW-1:0] fr_cnt,
  input logic          steer_pwm,
  input logic          drive_pwm,
  input logic          warn_o,
  input logic [1:0]    mode,
  input logic          threat,
  input logic          take_now
);

  logic [FW-1:0] fr_prev_q;
  int unsigned   gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_prev_q <= '0;
      gap_q     <= 0;
    end else begin
      fr_prev_q <= fr_cnt;
      gap_q     <= (fr_cnt != fr_prev_q) ? 1 : gap_q + 1;
    end
  end

  // R2: the frame position moves once per TICK_DIV clocks
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_cnt != fr_prev_q) |-> (gap_q == TICK_DIV));

  // R1: pulses start only at the frame start
  a_r1_steer_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_pwm) |-> (fr_cnt == '0));
  a_r1_drive_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_pwm) |-> (fr_cnt == '0));

  // R3 / R4: every pulse ends inside the legal width range
  a_r3_steer_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_pwm) |-> (fr_cnt >= FW'(W_MIN) && fr_cnt <= FW'(W_MAX)));
  a_r4_drive_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_pwm) |-> (fr_cnt >= FW'(W_MIN) && fr_cnt <= FW'(W_MAX)));

  // R8: manual modes never select the safety source
  a_r8_manual_user: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd1) |-> !take_now);

  // R10: the warning only appears with a threat in the warning mode
  a_r10_warn_cond: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |-> (mode == 2'd2 && threat));

endmodule

bind servo_pulse_gen servo_pulse_chk #(
  .TICK_DIV(TICK_DIV), .FW(FW), .W_MIN(W_MIN), .W_MAX(W_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_i), .fr_cnt(fr_cnt_q), .steer_pwm(steer_pwm),
  .drive_pwm(drive_pwm), .warn_o(warn_o), .mode(mode), .threat(threat),
  .take_now(take_now)
);

// File: tb/servo_pulse_gen_test.sv
module servo_pulse_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int D   = 2;
  localparam int F   = 40;
  localparam int WRN = 2;
  localparam int FRM = D * F;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [2:0] wr_data;
  logic [1:0] mode;
  logic       threat;
  logic       steer_pwm, drive_pwm, warn_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string req = "R7";

  // model state
  int m_sync, m_k, m_cnt;
  int m_us, m_ud, m_ss, m_sd;
  int m_ws, m_wd;
  bit m_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_pulse_gen #(
    .TICK_DIV(D), .FRAME_TICKS(F), .W_MIN(10), .W_SLO(14), .W_MID(15),
    .W_SHI(16), .W_MAX(20), .WARN_FRAMES(WRN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .threat(threat),
    .steer_pwm(steer_pwm), .drive_pwm(drive_pwm), .warn_o(warn_o)
  );

  function automatic int steer_w(int c);
    case (c)
      1: return 10;
      2: return 14;
      3: return 16;
      4: return 20;
      default: return 15;
    endcase
  endfunction

  function automatic int drive_w(int c);
    case (c)
      1: return 10;
      2: return 20;
      default: return 15;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_k = 0; m_cnt = 0; m_src = 1'b0;
      m_us = 0; m_ud = 0; m_ss = 0; m_sd = 0;
      m_ws = 15; m_wd = 15;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit pend, take;
      pend = (mode == 2'd2) && threat;
      if (((m_k + 1) % FRM) == 0) begin
        take = ((mode == 2'd3) && threat) || (pend && m_cnt >= WRN);
        m_src = take;
        m_ws = steer_w(take ? m_ss : m_us);
        m_wd = drive_w(take ? m_sd : m_ud);
        if (pend && m_cnt < WRN) m_cnt++;
      end
      if (!pend) m_cnt = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_us = wr_data;
          2'd1: m_ud = wr_data % 4;
          2'd2: m_ss = wr_data;
          default: m_sd = wr_data % 4;
        endcase
      end
      m_k++;
    end
  end

  task automatic check1(string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      int pos;
      pos = (m_k / D) % F;
      check1("steer_pwm", steer_pwm, pos < m_ws);
      check1("drive_pwm", drive_pwm, pos < m_wd);
      check1("warn_o", warn_o, (mode == 2'd2) && threat && !m_src);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [2:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycles(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mode = 2'd1; threat = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    chk_on = 1'b1;
    // R7: reset values, full frames with default commands
    req = "R7 R1 R2";
    cycles(2 * FRM);
    // R3: every steering code, including the fall-back codes
    req = "R3 R1";
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, c[2:0]);
      cycles(2 * FRM);
    end
    // R4 R5: drive codes, bit 2 set must be ignored
    req = "R4 R5";
    for (int c = 0; c < 4; c++) begin
      wr(2'd1, 3'(c) | 3'b100);
      cycles(2 * FRM);
    end
    // R6: writes in the middle of a pulse
    req = "R6";
    cycles(7);
    wr(2'd0, 3'd4);
    wr(2'd1, 3'd2);
    cycles(FRM + 3);
    wr(2'd0, 3'd1);
    cycles(FRM);
    // R8: manual mode ignores threat
    req = "R8";
    wr(2'd2, 3'd3);
    wr(2'd3, 3'd2);
    wr(2'd0, 3'd2);
    wr(2'd1, 3'd1);
    threat = 1'b1;
    cycles(3 * FRM);
    mode = 2'd0;
    cycles(2 * FRM);
    // R9: immediate takeover and release
    req = "R9";
    mode = 2'd3;
    cycles(3 * FRM);
    threat = 1'b0;
    cycles(2 * FRM);
    // R10: warn then take over
    req = "R10";
    mode = 2'd2;
    threat = 1'b1;
    cycles(6 * FRM);
    // R11: short threat drop clears the count
    req = "R11";
    threat = 1'b0;
    cycles(1);
    threat = 1'b1;
    cycles(FRM + 5);
    mode = 2'd1;
    cycles(1);
    mode = 2'd2;
    cycles(4 * FRM);
    threat = 1'b0;
    cycles(2 * FRM);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule